// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Controller

This block decides, every cycle, how an in-order five-stage integer pipeline advances. The pipeline has no operand forwarding and a single memory port shared by instruction fetch and data access. The surrounding datapath presents the state of its decode, execute, memory and writeback stages: valid bits, register numbers, write enables, the memory-access flag and the branch flags. The block returns purely combinational controls. These are a fetch enable for the shared port, a program-counter hold, a program-counter redirect, a decode hold, and three kill strobes that load a bubble into the fetch/decode, decode/execute and execute/memory registers.

Registers are read in decode and written at the end of writeback. A consumer in decode therefore waits until no older valid writer of one of its sources remains in execute, memory or writeback. A load or store in the memory stage takes the port, so fetch pauses for that cycle and decode receives a bubble. A taken branch squashes the younger wrong-path slots. The parameter `EARLY_BRANCH` selects where the branch resolves: in the memory stage (three slots squashed) or in decode (one slot squashed).

Top module: `ilk_pipe_interlock`

## Requirements
- R1: While `rst` is high, `ifid_kill`, `idex_kill` and `exmem_kill` are 1 and `fetch_en`, `pc_hold`, `pc_redirect` and `ifid_hold` are 0, whatever the stage inputs are.
- R2: A valid decode instruction that uses a nonzero source register equal to the destination of a valid, write-enabled instruction in execute, memory or writeback causes a RAW stall. During the stall `pc_hold`, `ifid_hold` and `idex_kill` are 1 and `fetch_en` is 0.
- R3: A source numbered 0, an unused source, or a match against a stage that is invalid or has its write enable low never causes a stall.
- R4: When the memory stage holds a valid load or store, `fetch_en` is 0 and `pc_hold` is 1. `ifid_kill` is 1 unless a RAW stall holds decode. `exmem_kill` stays 0, and execute and memory advance normally.
- R5: With `EARLY_BRANCH`=0, a valid taken branch in the memory stage drives `pc_redirect` and all three kill strobes to 1, and `fetch_en` to 0.
- R6: With `EARLY_BRANCH`=1, a valid taken branch in decode that has no RAW hazard drives `pc_redirect` and `ifid_kill` to 1, and `idex_kill` and `exmem_kill` stay 0. A branch that still has a RAW hazard stalls under R2 and does not redirect.
- R7: A redirect takes priority over the port stall and the RAW stall: `pc_hold` and `ifid_hold` are 0 during a redirect. An instruction squashed by the redirect triggers no stall.
- R8: Every instruction that reaches writeback has read the same operand values that strictly sequential execution of the program would have given it. Wrong-path instructions never reach writeback.
- R9: A branch whose taken flag is 0 has no effect on any control output.
- R10: With no redirect, no port use and no RAW stall, `fetch_en` is 1 and all hold, redirect and kill outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only for sampling the checks |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_W | First source register in decode |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | REG_W | Second source register in decode |
| id_rs2_en | input | 1 | Second source is read |
| id_is_branch | input | 1 | Decode instruction is a branch |
| id_br_taken | input | 1 | Outcome computed in decode (early mode) |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rd | input | REG_W | Execute destination register |
| ex_we | input | 1 | Execute instruction writes its destination |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes its destination |
| mem_access | input | 1 | Memory-stage instruction is a load or store |
| mem_is_branch | input | 1 | Memory-stage instruction is a branch |
| mem_br_taken | input | 1 | Outcome computed by the memory stage (late mode) |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_rd | input | REG_W | Writeback destination register |
| wb_we | input | 1 | Writeback instruction writes its destination |
| fetch_en | output | 1 | Fetch may use the shared memory port this cycle |
| pc_hold | output | 1 | Program counter keeps its value |
| pc_redirect | output | 1 | Program counter loads the branch target |
| ifid_hold | output | 1 | Fetch/decode register keeps its contents |
| ifid_kill | output | 1 | Fetch/decode register loads a bubble |
| idex_kill | output | 1 | Decode/execute register loads a bubble |
| exmem_kill | output | 1 | Execute/memory register loads a bubble |

## Verification
Each cycle, the assertions check the fixed relations between outputs and inputs: fetch is off whenever the memory stage uses the port, no hold appears alongside a redirect, a decode hold always comes with a PC hold, register 0 and non-writing producers never stall, the late branch squashes three slots, the early branch waits out its own RAW hazard, and reset forces the kill pattern. What only the bench's scenarios can show is that the stall and squash decisions, applied over many cycles to a running pipeline model, yield correct program results. A stall released one cycle too early, a kill on the wrong slot, or a squashed instruction that still holds decode would each corrupt an operand seen at writeback, and the bench compares those operands against a sequential interpretation of the same program in both branch modes.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Pipeline register slots that a squash can clear, youngest first.
  localparam int unsigned SLOT_IFID  = 0;
  localparam int unsigned SLOT_IDEX  = 1;
  localparam int unsigned SLOT_EXMEM = 2;
  localparam int unsigned NUM_SLOTS  = 3;

  // Older stages that may still owe a register write to decode.
  localparam int unsigned NUM_PRODUCERS = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_RAW,
    CAUSE_PORT,
    CAUSE_REDIRECT
  } ilk_cause_e;

  // Single place where the ordering between the three reasons is decided.
  function automatic ilk_cause_e pick_cause(input logic redirect,
                                            input logic port_busy,
                                            input logic raw_hit);
    if (redirect)       return CAUSE_REDIRECT;
    else if (port_busy) return CAUSE_PORT;
    else if (raw_hit)   return CAUSE_RAW;
    else                return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/ilk_raw_detect.sv
module ilk_raw_detect #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned NUM_PROD = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cons_valid,
  input  logic [NUM_SRC*REG_W-1:0]  src_addr,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_PROD*REG_W-1:0] prod_rd,
  input  logic [NUM_PROD-1:0]       prod_valid,
  input  logic [NUM_PROD-1:0]       prod_we,
  output logic                      raw_hit
);

  localparam int unsigned NUM_PAIRS = NUM_SRC * NUM_PROD;

  logic [NUM_PAIRS-1:0] pair_hit;
  logic [NUM_SRC-1:0]   src_live;
  logic [NUM_PROD-1:0]  prod_live;

  // A producer counts only if it is real and will write back.
  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    assign prod_live[p] = prod_valid[p] & prod_we[p];
  end

  // A source counts only if it is read and is not the zero register.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [REG_W-1:0] addr_s;
    assign addr_s      = src_addr[s*REG_W +: REG_W];
    assign src_live[s] = cons_valid & src_en[s] & (addr_s != '0);
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_pair
      assign pair_hit[s*NUM_PROD+p] = src_live[s] & prod_live[p] &
                                      (prod_rd[p*REG_W +: REG_W] == addr_s);
    end
  end

  assign raw_hit = |pair_hit;

  AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (src_addr == '0) |-> !raw_hit); // R3

  AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    ((prod_valid & prod_we) == '0) |-> !raw_hit); // R3

  AST_IDLE_CONSUMER_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!cons_valid || src_en == '0) |-> !raw_hit); // R3

endmodule

// File: rtl/ilk_port_arb.sv
module ilk_port_arb (
  input  logic mem_valid,
  input  logic mem_access,
  output logic port_busy
);

  // The data side owns the single port whenever a real load or store sits
  // in the memory stage; fetch gets it in every other cycle.
  assign port_busy = mem_valid & mem_access;

endmodule

// File: rtl/ilk_branch_squash.sv
module ilk_branch_squash
  import ilk_pkg::*;
#(
  parameter bit EARLY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 id_taken,
  input  logic                 id_raw,
  input  logic                 mem_taken,
  output logic                 redirect,
  output logic [NUM_SLOTS-1:0] kill_mask
);

  // Late resolution leaves three younger slots on the wrong path;
  // resolution in decode leaves only the slot just fetched.
  localparam int unsigned SQUASH_SLOTS = EARLY ? 1 : NUM_SLOTS;

  logic early_fire;
  logic late_fire;

  // An early branch must read clean operands before it may resolve.
  assign early_fire = id_taken & ~id_raw;
  assign late_fire  = mem_taken;
  assign redirect   = EARLY ? early_fire : late_fire;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < SQUASH_SLOTS) begin : g_kill
      assign kill_mask[s] = redirect;
    end else begin : g_keep
      assign kill_mask[s] = 1'b0;
    end
  end

  AST_EARLY_WAITS_FOR_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    (EARLY && id_raw) |-> !redirect); // R6

  AST_SQUASH_FROM_YOUNGEST: assert property (@(posedge clk) disable iff (rst)
    kill_mask[SLOT_EXMEM] |-> (kill_mask[SLOT_IDEX] && kill_mask[SLOT_IFID])); // R5

endmodule

// File: rtl/ilk_ctl_prio.sv
module ilk_ctl_prio
  import ilk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 redirect,
  input  logic [NUM_SLOTS-1:0] kill_mask,
  input  logic                 port_busy,
  input  logic                 raw_hit,
  output logic                 fetch_en,
  output logic                 pc_hold,
  output logic                 pc_redirect,
  output logic                 ifid_hold,
  output logic                 ifid_kill,
  output logic                 idex_kill,
  output logic                 exmem_kill
);

  logic       raw_live;
  ilk_cause_e cause;

  // A decode instruction about to be squashed must not hold anything up.
  assign raw_live = raw_hit & ~kill_mask[SLOT_IDEX];
  assign cause    = pick_cause(redirect, port_busy, raw_live);

  always_comb begin
    fetch_en    = 1'b0;
    pc_hold     = 1'b0;
    pc_redirect = 1'b0;
    ifid_hold   = 1'b0;
    ifid_kill   = 1'b0;
    idex_kill   = 1'b0;
    exmem_kill  = 1'b0;
    if (rst) begin
      ifid_kill  = 1'b1;
      idex_kill  = 1'b1;
      exmem_kill = 1'b1;
    end else begin
      unique case (cause)
        CAUSE_REDIRECT: begin
          pc_redirect = 1'b1;
          ifid_kill   = kill_mask[SLOT_IFID];
          idex_kill   = kill_mask[SLOT_IDEX];
          exmem_kill  = kill_mask[SLOT_EXMEM];
        end
        CAUSE_PORT: begin
          pc_hold = 1'b1;
          if (raw_live) begin
            ifid_hold = 1'b1;
            idex_kill = 1'b1;
          end else begin
            ifid_kill = 1'b1;
          end
        end
        CAUSE_RAW: begin
          pc_hold   = 1'b1;
          ifid_hold = 1'b1;
          idex_kill = 1'b1;
        end
        default: begin
          fetch_en = 1'b1;
        end
      endcase
    end
  end

  AST_RESET_EMPTIES_PIPE: assert property (@(posedge clk)
    rst |-> (ifid_kill && idex_kill && exmem_kill && !fetch_en && !pc_hold)); // R1

  AST_REDIRECT_BEATS_HOLD: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> (!pc_hold && !ifid_hold)); // R7

  AST_DECODE_HOLD_NEEDS_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |-> (pc_hold && idex_kill && !ifid_kill)); // R2

  AST_FETCH_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> (!pc_hold && !pc_redirect && !ifid_kill && !idex_kill)); // R10

endmodule

// File: rtl/ilk_pipe_interlock.sv
module ilk_pipe_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W        = 5,
  parameter bit          EARLY_BRANCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic             id_rs1_en,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_rs2_en,
  input  logic             id_is_branch,
  input  logic             id_br_taken,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             mem_access,
  input  logic             mem_is_branch,
  input  logic             mem_br_taken,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic             fetch_en,
  output logic             pc_hold,
  output logic             pc_redirect,
  output logic             ifid_hold,
  output logic             ifid_kill,
  output logic             idex_kill,
  output logic             exmem_kill
);

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC*REG_W-1:0]       src_addr;
  logic [NUM_SRC-1:0]             src_en;
  logic [NUM_PRODUCERS*REG_W-1:0] prod_rd;
  logic [NUM_PRODUCERS-1:0]       prod_valid;
  logic [NUM_PRODUCERS-1:0]       prod_we;
  logic                           raw_hit;
  logic                           port_busy;
  logic                           redirect;
  logic [NUM_SLOTS-1:0]           kill_mask;
  logic                           id_taken;
  logic                           mem_taken;

  assign src_addr   = {id_rs2, id_rs1};
  assign src_en     = {id_rs2_en, id_rs1_en};
  assign prod_rd    = {wb_rd, mem_rd, ex_rd};
  assign prod_valid = {wb_valid, mem_valid, ex_valid};
  assign prod_we    = {wb_we, mem_we, ex_we};
  assign id_taken   = id_valid & id_is_branch & id_br_taken;
  assign mem_taken  = mem_valid & mem_is_branch & mem_br_taken;

  ilk_raw_detect #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC),
    .NUM_PROD(NUM_PRODUCERS)
  ) u_raw (
    .clk       (clk),
    .rst       (rst),
    .cons_valid(id_valid),
    .src_addr  (src_addr),
    .src_en    (src_en),
    .prod_rd   (prod_rd),
    .prod_valid(prod_valid),
    .prod_we   (prod_we),
    .raw_hit   (raw_hit)
  );

  ilk_port_arb u_port (
    .mem_valid (mem_valid),
    .mem_access(mem_access),
    .port_busy (port_busy)
  );

  ilk_branch_squash #(
    .EARLY(EARLY_BRANCH)
  ) u_branch (
    .clk      (clk),
    .rst      (rst),
    .id_taken (id_taken),
    .id_raw   (raw_hit),
    .mem_taken(mem_taken),
    .redirect (redirect),
    .kill_mask(kill_mask)
  );

  ilk_ctl_prio u_prio (
    .clk        (clk),
    .rst        (rst),
    .redirect   (redirect),
    .kill_mask  (kill_mask),
    .port_busy  (port_busy),
    .raw_hit    (raw_hit),
    .fetch_en   (fetch_en),
    .pc_hold    (pc_hold),
    .pc_redirect(pc_redirect),
    .ifid_hold  (ifid_hold),
    .ifid_kill  (ifid_kill),
    .idex_kill  (idex_kill),
    .exmem_kill (exmem_kill)
  );

  AST_PORT_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_access) |-> (!fetch_en && (pc_hold || pc_redirect))); // R4

  AST_PORT_KEEPS_BACK_END: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_access && !pc_redirect) |-> !exmem_kill); // R4

  AST_LATE_BRANCH_THREE_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (!EARLY_BRANCH && mem_valid && mem_is_branch && mem_br_taken)
      |-> (pc_redirect && ifid_kill && idex_kill && exmem_kill)); // R5

  AST_EARLY_BRANCH_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (EARLY_BRANCH && pc_redirect) |-> (ifid_kill && !idex_kill && !exmem_kill)); // R6

  AST_UNTAKEN_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (!(id_valid && id_is_branch && id_br_taken) &&
     !(mem_valid && mem_is_branch && mem_br_taken)) |-> !pc_redirect); // R9

endmodule

// File: tb/ilk_pipe_interlock_tb.sv
module ilk_pipe_interlock_tb;

  localparam int REG_W = 5;
  localparam int NPROG = 22;

  typedef struct {
    bit   v;
    int   idx;
    logic [REG_W-1:0] rd, rs1, rs2;
    bit   u1, u2, we, mem, br, tk;
    int   tgt;
    int   a, b;
  } st_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int   tests = 0;
  int   fails = 0;
  int   mode  = 0;
  bit   done_all = 1'b0;

  st_t  prog [NPROG];
  st_t  s_id, s_ex, s_mem, s_wb;
  int   pc;
  int   rf [32];
  int   gold_idx[$], gold_a[$], gold_b[$];

  // Shared stimulus wires for both design instances.
  logic id_valid, id_rs1_en, id_rs2_en, id_is_branch, id_br_taken;
  logic [REG_W-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_valid, ex_we, mem_valid, mem_we, mem_access, mem_is_branch, mem_br_taken;
  logic wb_valid, wb_we;

  assign id_valid     = s_id.v;
  assign id_rs1       = s_id.rs1;
  assign id_rs1_en    = s_id.u1;
  assign id_rs2       = s_id.rs2;
  assign id_rs2_en    = s_id.u2;
  assign id_is_branch = s_id.br;
  assign id_br_taken  = s_id.tk;
  assign ex_valid     = s_ex.v;
  assign ex_rd        = s_ex.rd;
  assign ex_we        = s_ex.we;
  assign mem_valid    = s_mem.v;
  assign mem_rd       = s_mem.rd;
  assign mem_we       = s_mem.we;
  assign mem_access   = s_mem.mem;
  assign mem_is_branch = s_mem.br;
  assign mem_br_taken = s_mem.tk;
  assign wb_valid     = s_wb.v;
  assign wb_rd        = s_wb.rd;
  assign wb_we        = s_wb.we;

  logic [6:0] o_late, o_early;

  ilk_pipe_interlock #(.REG_W(REG_W), .EARLY_BRANCH(1'b0)) u_dut (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs1_en(id_rs1_en),
    .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
    .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_we(ex_we),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_we(mem_we), .mem_access(mem_access),
    .mem_is_branch(mem_is_branch), .mem_br_taken(mem_br_taken),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_we(wb_we),
    .fetch_en(o_late[6]), .pc_hold(o_late[5]), .pc_redirect(o_late[4]),
    .ifid_hold(o_late[3]), .ifid_kill(o_late[2]), .idex_kill(o_late[1]),
    .exmem_kill(o_late[0])
  );

  ilk_pipe_interlock #(.REG_W(REG_W), .EARLY_BRANCH(1'b1)) u_dut_early (
    .clk(clk), .rst(rst),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs1_en(id_rs1_en),
    .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
    .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_we(ex_we),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_we(mem_we), .mem_access(mem_access),
    .mem_is_branch(mem_is_branch), .mem_br_taken(mem_br_taken),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_we(wb_we),
    .fetch_en(o_early[6]), .pc_hold(o_early[5]), .pc_redirect(o_early[4]),
    .ifid_hold(o_early[3]), .ifid_kill(o_early[2]), .idex_kill(o_early[1]),
    .exmem_kill(o_early[0])
  );

  function automatic st_t bubble();
    st_t t;
    t.v = 0; t.idx = -1; t.rd = '0; t.rs1 = '0; t.rs2 = '0;
    t.u1 = 0; t.u2 = 0; t.we = 0; t.mem = 0; t.br = 0; t.tk = 0;
    t.tgt = 0; t.a = 0; t.b = 0;
    return t;
  endfunction

  task automatic put(input int i, input int rd, input int rs1, input int rs2,
                     input bit u1, input bit u2, input bit we, input bit mem,
                     input bit br, input bit tk, input int tgt);
    prog[i] = bubble();
    prog[i].v = 1; prog[i].idx = i;
    prog[i].rd = rd[REG_W-1:0]; prog[i].rs1 = rs1[REG_W-1:0]; prog[i].rs2 = rs2[REG_W-1:0];
    prog[i].u1 = u1; prog[i].u2 = u2; prog[i].we = we; prog[i].mem = mem;
    prog[i].br = br; prog[i].tk = tk; prog[i].tgt = tgt;
  endtask

  task automatic build_prog();
    put(0, 1,0,0, 1,1,1,0, 0,0,0);   // reads r0 only
    put(1, 2,1,0, 1,1,1,0, 0,0,0);   // distance-1 RAW
    put(2, 3,2,1, 1,1,1,0, 0,0,0);
    put(3, 4,0,0, 0,0,1,0, 0,0,0);   // no sources
    put(4, 5,3,4, 1,1,1,0, 0,0,0);   // distance 2 and 1
    put(5, 6,1,0, 1,0,1,1, 0,0,0);   // load
    put(6, 7,6,5, 1,1,0,1, 0,0,0);   // store, rd field 7 but no write
    put(7, 7,7,0, 1,0,1,0, 0,0,0);   // reads r7 behind the store
    put(8, 0,7,0, 1,0,0,0, 1,1,12);  // taken branch
    put(9, 1,2,3, 1,1,1,0, 0,0,0);   // wrong path
    put(10,2,1,1, 1,1,1,0, 0,0,0);   // wrong path, depends on 9
    put(11,3,0,0, 1,1,1,0, 0,0,0);   // wrong path
    put(12,1,1,2, 1,1,1,0, 0,0,0);
    put(13,0,1,0, 1,0,0,0, 1,0,0);   // not-taken branch
    put(14,2,1,7, 1,1,1,0, 0,0,0);
    put(15,3,2,0, 1,0,1,1, 0,0,0);   // load
    put(16,4,0,0, 1,1,1,0, 0,0,0);
    put(17,5,3,4, 1,1,1,0, 0,0,0);
    put(18,0,0,0, 0,0,0,0, 1,1,20);  // taken branch, no sources
    put(19,6,1,1, 1,1,1,0, 0,0,0);   // wrong path
    put(20,6,5,4, 1,1,1,0, 0,0,0);
    put(21,7,6,6, 1,1,1,0, 0,0,0);
  endtask

  // Strictly sequential interpretation of the program.
  task automatic build_gold();
    int g [32];
    int p;
    for (int r = 0; r < 32; r++) g[r] = 0;
    gold_idx.delete(); gold_a.delete(); gold_b.delete();
    p = 0;
    while (p < NPROG) begin
      int a, b;
      a = prog[p].u1 ? g[prog[p].rs1] : 0;
      b = prog[p].u2 ? g[prog[p].rs2] : 0;
      gold_idx.push_back(p); gold_a.push_back(a); gold_b.push_back(b);
      if (prog[p].we && prog[p].rd != 0) g[prog[p].rd] = a + b + p + 1;
      p = (prog[p].br && prog[p].tk) ? prog[p].tgt : p + 1;
    end
  endtask

  function automatic bit pending(input logic [REG_W-1:0] r);
    return (s_ex.v && s_ex.we && s_ex.rd == r) ||
           (s_mem.v && s_mem.we && s_mem.rd == r) ||
           (s_wb.v && s_wb.we && s_wb.rd == r);
  endfunction

  function automatic bit idle_name(input logic [REG_W-1:0] r);
    return (r == 0) || (s_ex.rd == r && !(s_ex.v && s_ex.we)) ||
           (s_mem.rd == r && !(s_mem.v && s_mem.we));
  endfunction

  // Expected controls, bit order {fetch, pc_hold, redirect, ifid_hold,
  // ifid_kill, idex_kill, exmem_kill}, plus the requirement tag of the cycle.
  task automatic expect_ctl(output logic [6:0] e, output string tag);
    bit raw, busy, redir, rawl;
    raw = s_id.v && ((s_id.u1 && s_id.rs1 != 0 && pending(s_id.rs1)) ||
                     (s_id.u2 && s_id.rs2 != 0 && pending(s_id.rs2)));
    busy = s_mem.v && s_mem.mem;
    if (mode == 0) redir = s_mem.v && s_mem.br && s_mem.tk;
    else           redir = s_id.v && s_id.br && s_id.tk && !raw;
    rawl = raw && !(redir && mode == 0);
    if (rst) begin
      e = 7'b0000111; tag = "R1";
    end else begin
      e[6] = !(redir || busy || rawl);
      e[5] = !redir && (busy || rawl);
      e[4] = redir;
      e[3] = !redir && rawl;
      e[2] = redir || (busy && !rawl);
      e[1] = (redir && mode == 0) || (!redir && rawl);
      e[0] = redir && mode == 0;
      if (redir && (raw || busy))   tag = "R7";
      else if (redir)               tag = (mode == 0) ? "R5" : "R6";
      else if (busy)                tag = "R4";
      else if (rawl)                tag = "R2";
      else if ((s_id.v && s_id.br && !s_id.tk) || (s_mem.v && s_mem.br && !s_mem.tk))
                                    tag = "R9";
      else if (s_id.v && ((s_id.u1 && idle_name(s_id.rs1)) || (s_id.u2 && idle_name(s_id.rs2))))
                                    tag = "R3";
      else                          tag = "R10";
    end
  endtask

  task automatic compare_ctl();
    logic [6:0] e, act;
    string tag;
    string names [7] = '{"exmem_kill","idex_kill","ifid_kill","ifid_hold",
                         "pc_redirect","pc_hold","fetch_en"};
    act = (mode == 0) ? o_late : o_early;
    expect_ctl(e, tag);
    for (int i = 0; i < 7; i++) begin
      tests++;
      if (act[i] !== e[i]) begin
        fails++;
        $display("FAIL %s mode=%0d %s actual=%b expected=%b", tag, mode, names[i], act[i], e[i]);
      end
    end
  endtask

  // One clock of the behavioural pipeline, steered by the design's outputs.
  task automatic step();
    logic [6:0] o;
    st_t nid, nex, nmem, nwb;
    o = (mode == 0) ? o_late : o_early;
    nex = o[1] ? bubble() : s_id;
    if (nex.v) begin
      nex.a = nex.u1 ? rf[nex.rs1] : 0;
      nex.b = nex.u2 ? rf[nex.rs2] : 0;
    end
    if (s_wb.v) begin
      tests++;
      if (gold_idx.size() == 0) begin
        fails++;
        $display("FAIL R8 extra retire idx actual=%0d expected=none", s_wb.idx);
      end else begin
        int gi, ga, gb;
        gi = gold_idx.pop_front(); ga = gold_a.pop_front(); gb = gold_b.pop_front();
        if (s_wb.idx != gi || s_wb.a != ga || s_wb.b != gb) begin
          fails++;
          $display("FAIL R8 mode=%0d retire actual=(%0d,%0d,%0d) expected=(%0d,%0d,%0d)",
                   mode, s_wb.idx, s_wb.a, s_wb.b, gi, ga, gb);
        end
      end
      if (s_wb.we && s_wb.rd != 0) rf[s_wb.rd] = s_wb.a + s_wb.b + s_wb.idx + 1;
    end
    nwb  = s_mem;
    nmem = o[0] ? bubble() : s_ex;
    if (o[2])      nid = bubble();
    else if (o[3]) nid = s_id;
    else if (o[6] && pc < NPROG) nid = prog[pc];
    else           nid = bubble();
    if (o[4])      pc = (mode == 0) ? s_mem.tgt : s_id.tgt;
    else if (!o[5] && o[6]) pc = pc + 1;
    s_id = nid; s_ex = nex; s_mem = nmem; s_wb = nwb;
  endtask

  task automatic run_mode(input int m);
    bit finished;
    mode = m;
    rst  = 1'b1;
    // Busy, dependent state during reset: must not leak through.
    s_id = prog[1]; s_ex = prog[0]; s_mem = prog[5]; s_wb = prog[8];
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      compare_ctl();
    end
    rst = 1'b0;
    s_id = bubble(); s_ex = bubble(); s_mem = bubble(); s_wb = bubble();
    pc = 0;
    for (int r = 0; r < 32; r++) rf[r] = 0;
    build_gold();
    finished = 0;
    for (int c = 0; c < 400 && !finished; c++) begin
      @(negedge clk);
      compare_ctl();
      step();
      finished = (pc >= NPROG) && !s_id.v && !s_ex.v && !s_mem.v && !s_wb.v;
    end
    tests++;
    if (!finished || gold_idx.size() != 0) begin
      fails++;
      $display("FAIL R8 mode=%0d program incomplete actual=%0d expected=0 left", m, gold_idx.size());
    end
  endtask

  initial begin
    s_id = bubble(); s_ex = bubble(); s_mem = bubble(); s_wb = bubble();
    pc = 0;
    build_prog();
    run_mode(0);
    run_mode(1);
    done_all = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done_all) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule